// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits at the front of a receive path and decides, from the six destination-address bytes at the head of a frame, whether the frame is kept. The bytes arrive one per `byte_valid_i` cycle after a `start_i` pulse. While they arrive, the block checks them against the all-ones broadcast pattern, the IPv4-style group prefix and the programmed station address. It also folds them into a serial CRC-32 that yields a 6-bit index into a 64-entry group hash table.

One cycle after the sixth byte is taken, `done_o` pulses for a single cycle. At that point the block presents:
- the accept verdict;
- the broadcast and multicast flags;
- the hash index.

These results hold until the next `start_i`. Payload bytes and frame CRC checking belong to other blocks.

The controller has three states:
- `S_IDLE` waits.
- `S_ADDR` takes address bytes.
- `S_REPORT` is the single done cycle.

Transitions:
- `S_IDLE -> S_ADDR` on start.
- `S_ADDR -> S_ADDR` on a restart.
- `S_ADDR -> S_REPORT` when the sixth byte is taken.
- `S_REPORT -> S_ADDR` on start, otherwise `S_REPORT -> S_IDLE`.

Top module: `rxaf_filter`

## Requirements
- R1: After reset, and after every `start_i`, `done_o`, `accept_o`, `bcast_o` and `mcast_o` are 0 and `hash_idx_o` is 0 until a new sixth byte is taken. A `start_i` pulse clears any partly received address. Address bytes are taken only on `byte_valid_i` cycles after the start cycle.
- R2: `done_o` is high for exactly the one cycle after the edge that takes the sixth byte.
- R3: A destination of six 0xFF bytes sets `bcast_o`. It is accepted only if `rx_all_i` or `acc_bcast_i` is 1.
- R4: `mcast_o` is set only when the bytes are 0x01, 0x00, 0x5E and a fourth byte of 0x7F or less. Any other destination, including one with a fourth byte of 0x80, is not multicast.
- R5: A multicast frame is accepted when `rx_all_i` or `acc_mcast_all_i` is 1. Otherwise it is accepted only when `hash_en_i` is 1 and the selected table bit is 1. Hash index bit 5 picks the word (0 for `hash_lo_i`, 1 for `hash_hi_i`), and bits 4:0 pick the bit within that word.
- R6: The hash is a CRC-32 with polynomial 0x04C11DB7, preset to all ones, with each byte fed LSB first. Each step uses the feedback crc[31] XOR data bit, and the register is inverted at the end. `hash_idx_o` is the top byte of the result, bit-reversed and shifted right by two.
- R7: When `gig_mode_i` is 1, only the first five bytes enter the CRC, so the sixth byte has no effect on `hash_idx_o`. When it is 0, all six bytes enter the CRC.
- R8: A frame that is neither broadcast nor multicast is accepted only when every byte equals the station address. The first received byte is compared with `station_addr_i[47:40]`, and the last with `[7:0]`.
- R9: Once `done_o` has pulsed, bytes presented before the next `start_i` are ignored, and all results hold their values.
- R10: With `rx_all_i` set, a non-matching unicast destination is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a new destination address and clears state |
| byte_valid_i | input | 1 | `byte_i` carries an address byte this cycle |
| byte_i | input | 8 | Address byte, first byte of the frame first |
| station_addr_i | input | 48 | Own address, first byte in bits 47:40 |
| hash_lo_i | input | 32 | Hash table entries 0 to 31 |
| hash_hi_i | input | 32 | Hash table entries 32 to 63 |
| rx_all_i | input | 1 | Accept every destination |
| acc_bcast_i | input | 1 | Accept broadcast |
| acc_mcast_all_i | input | 1 | Accept every multicast |
| hash_en_i | input | 1 | Enable hash-table multicast filtering |
| gig_mode_i | input | 1 | Fold five bytes into the hash instead of six |
| done_o | output | 1 | One-cycle result strobe |
| accept_o | output | 1 | Frame kept |
| bcast_o | output | 1 | Destination is broadcast |
| mcast_o | output | 1 | Destination is multicast |
| hash_idx_o | output | 6 | Computed hash index |

## Verification
The bench aims at the hash path. It checks the index against an independent bit-serial model in both byte-count modes, and it puts the table bit in the wrong word. A design that swapped the word select, or the bit order of the index, would accept the wrong groups. A design that folded the sixth byte in gigabit mode would return a different index.

The bench also tries a group prefix whose fourth byte is 0x80, a station address presented in reverse byte order, and a restart in the middle of an address. These catch a loose prefix compare, a reversed byte lane, or state that survives a restart. Stray bytes after the result must leave every output unchanged.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ADDR   = 2'd1,
        S_REPORT = 2'd2
    } rxaf_state_e;

    localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    localparam logic [7:0] GRP_B0  = 8'h01;
    localparam logic [7:0] GRP_B1  = 8'h00;
    localparam logic [7:0] GRP_B2  = 8'h5E;
    localparam logic [7:0] ALL_ONE = 8'hFF;

endpackage

// File: rtl/rxaf_crc_hash.sv
module rxaf_crc_hash
    import rxaf_pkg::*;
#(
    parameter int HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              fold_i,
    input  logic [7:0]        byte_i,
    output logic [HASH_W-1:0] idx_o
);
    logic [31:0] crc_q;
    logic [31:0] crc_d;
    logic [7:0]  top_inv;

    // One byte per step, shifted through the register LSB first
    always_comb begin
        crc_d = crc_q;
        for (int i = 0; i < 8; i++) begin
            if (crc_d[31] ^ byte_i[i]) begin
                crc_d = {crc_d[30:0], 1'b0} ^ CRC_POLY;
            end else begin
                crc_d = {crc_d[30:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
        end else if (clear_i) begin
            crc_q <= CRC_PRESET;
        end else if (fold_i) begin
            crc_q <= crc_d;
        end
    end

    // Inverted top byte, reversed, upper HASH_W bits of the reversal
    always_comb begin
        top_inv = ~crc_q[31:24];
        for (int k = 0; k < HASH_W; k++) begin
            idx_o[k] = top_inv[(8 - HASH_W) + (HASH_W - 1) - k - (8 - HASH_W)];
        end
    end

endmodule

// File: rtl/rxaf_addr_match.sv
module rxaf_addr_match
    import rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int POS_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    take_i,
    input  logic [POS_W-1:0]        pos_i,
    input  logic [7:0]              byte_i,
    input  logic [8*ADDR_BYTES-1:0] station_i,
    output logic                    is_bcast_o,
    output logic                    is_mcast_o,
    output logic                    station_hit_o
);
    logic       bc_q, mc_q, st_q;
    logic [7:0] st_byte;
    logic       mc_ok;

    // Station byte for this position, first byte in the top lane
    always_comb begin
        st_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (pos_i == POS_W'(k)) begin
                st_byte = station_i[(ADDR_BYTES-1-k)*8 +: 8];
            end
        end
    end

    // Group prefix check, position dependent
    always_comb begin
        unique case (pos_i)
            POS_W'(0): mc_ok = (byte_i == GRP_B0);
            POS_W'(1): mc_ok = (byte_i == GRP_B1);
            POS_W'(2): mc_ok = (byte_i == GRP_B2);
            POS_W'(3): mc_ok = ~byte_i[7];
            default:   mc_ok = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q <= 1'b0;
            mc_q <= 1'b0;
            st_q <= 1'b0;
        end else if (clear_i) begin
            bc_q <= 1'b1;
            mc_q <= 1'b1;
            st_q <= 1'b1;
        end else if (take_i) begin
            bc_q <= bc_q & (byte_i == ALL_ONE);
            mc_q <= mc_q & mc_ok;
            st_q <= st_q & (byte_i == st_byte);
        end
    end

    assign is_bcast_o    = bc_q;
    assign is_mcast_o    = mc_q;
    assign station_hit_o = st_q;

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide #(
    parameter int HASH_W = 6,
    parameter int WORD_W = 32
) (
    input  logic              is_bcast_i,
    input  logic              is_mcast_i,
    input  logic              station_hit_i,
    input  logic [HASH_W-1:0] idx_i,
    input  logic [WORD_W-1:0] tbl_lo_i,
    input  logic [WORD_W-1:0] tbl_hi_i,
    input  logic              rx_all_i,
    input  logic              acc_bcast_i,
    input  logic              acc_mcast_all_i,
    input  logic              hash_en_i,
    output logic              accept_o
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] word;
    logic              tbl_hit;

    always_comb begin
        word    = idx_i[HASH_W-1] ? tbl_hi_i : tbl_lo_i;
        tbl_hit = word[idx_i[BIT_W-1:0]];
        if (is_bcast_i) begin
            accept_o = rx_all_i | acc_bcast_i;
        end else if (is_mcast_i) begin
            accept_o = rx_all_i | acc_mcast_all_i | (hash_en_i & tbl_hit);
        end else begin
            accept_o = rx_all_i | station_hit_i;
        end
    end

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
    import rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int FOLD_GIG   = 5,
    parameter int HASH_W     = 6,
    parameter int WORD_W     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_i,
    input  logic [47:0] station_addr_i,
    input  logic [31:0] hash_lo_i,
    input  logic [31:0] hash_hi_i,
    input  logic        rx_all_i,
    input  logic        acc_bcast_i,
    input  logic        acc_mcast_all_i,
    input  logic        hash_en_i,
    input  logic        gig_mode_i,
    output logic        done_o,
    output logic        accept_o,
    output logic        bcast_o,
    output logic        mcast_o,
    output logic [5:0]  hash_idx_o
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    rxaf_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] fold_lim;
    logic             take, fold, full;
    logic             is_bc, is_mc, st_hit, verdict;
    logic [5:0]       idx;

    assign take     = (state_q == S_ADDR) && byte_valid_i && !start_i;
    assign fold_lim = gig_mode_i ? CNT_W'(FOLD_GIG) : CNT_W'(ADDR_BYTES);
    assign fold     = take && (cnt_q < fold_lim);
    assign full     = (cnt_q == CNT_W'(ADDR_BYTES));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = S_ADDR;
            end
            S_ADDR: begin
                if (start_i) begin
                    state_d = S_ADDR;
                end else if (take && cnt_q == CNT_W'(ADDR_BYTES - 1)) begin
                    state_d = S_REPORT;
                end
            end
            S_REPORT: begin
                state_d = start_i ? S_ADDR : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                cnt_q <= '0;
            end else if (take) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    rxaf_crc_hash #(.HASH_W(HASH_W)) u_hash (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .fold_i  (fold),
        .byte_i  (byte_i),
        .idx_o   (idx)
    );

    rxaf_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (start_i),
        .take_i        (take),
        .pos_i         (cnt_q),
        .byte_i        (byte_i),
        .station_i     (station_addr_i),
        .is_bcast_o    (is_bc),
        .is_mcast_o    (is_mc),
        .station_hit_o (st_hit)
    );

    rxaf_decide #(.HASH_W(HASH_W), .WORD_W(WORD_W)) u_decide (
        .is_bcast_i      (is_bc),
        .is_mcast_i      (is_mc),
        .station_hit_i   (st_hit),
        .idx_i           (idx),
        .tbl_lo_i        (hash_lo_i),
        .tbl_hi_i        (hash_hi_i),
        .rx_all_i        (rx_all_i),
        .acc_bcast_i     (acc_bcast_i),
        .acc_mcast_all_i (acc_mcast_all_i),
        .hash_en_i       (hash_en_i),
        .accept_o        (verdict)
    );

    always_comb begin
        done_o     = (state_q == S_REPORT);
        accept_o   = full & verdict;
        bcast_o    = full & is_bc;
        mcast_o    = full & is_mc;
        hash_idx_o = full ? idx : '0;
    end

endmodule

// File: rtl/rxaf_filter_chk.sv
module rxaf_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       rx_all_i,
    input logic       acc_bcast_i,
    input logic       acc_mcast_all_i,
    input logic       hash_en_i,
    input logic       done_o,
    input logic       accept_o,
    input logic       bcast_o,
    input logic       mcast_o,
    input logic [5:0] hash_idx_o
);
    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !accept_o && !bcast_o && !mcast_o));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_bcast_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && bcast_o && !rx_all_i && !acc_bcast_i) |-> !accept_o);

    assert_bcast_not_mcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(bcast_o && mcast_o));

    assert_mcast_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mcast_o && !rx_all_i && !acc_mcast_all_i && !hash_en_i) |-> !accept_o);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(hash_idx_o) && $stable(bcast_o) && $stable(mcast_o)));

endmodule

bind rxaf_filter rxaf_filter_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .rx_all_i        (rx_all_i),
    .acc_bcast_i     (acc_bcast_i),
    .acc_mcast_all_i (acc_mcast_all_i),
    .hash_en_i       (hash_en_i),
    .done_o          (done_o),
    .accept_o        (accept_o),
    .bcast_o         (bcast_o),
    .mcast_o         (mcast_o),
    .hash_idx_o      (hash_idx_o)
);

// File: tb/tb_rxaf_filter.sv
module tb_rxaf_filter;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [31:0] hash_lo_i = '0;
    logic [31:0] hash_hi_i = '0;
    logic        rx_all_i = 1'b0;
    logic        acc_bcast_i = 1'b0;
    logic        acc_mcast_all_i = 1'b0;
    logic        hash_en_i = 1'b0;
    logic        gig_mode_i = 1'b0;
    logic        done_o, accept_o, bcast_o, mcast_o;
    logic [5:0]  hash_idx_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxaf_filter dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .station_addr_i(STATION), .hash_lo_i(hash_lo_i),
        .hash_hi_i(hash_hi_i), .rx_all_i(rx_all_i), .acc_bcast_i(acc_bcast_i),
        .acc_mcast_all_i(acc_mcast_all_i), .hash_en_i(hash_en_i),
        .gig_mode_i(gig_mode_i), .done_o(done_o), .accept_o(accept_o),
        .bcast_o(bcast_o), .mcast_o(mcast_o), .hash_idx_o(hash_idx_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_idx(input logic [47:0] a, input int n);
        logic [31:0] crc = 32'hFFFF_FFFF;
        logic [7:0]  t;
        logic [7:0]  r;
        for (int i = 0; i < n; i++) begin
            logic [7:0] c = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                logic fb = crc[31] ^ c[j];
                crc = {crc[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        crc = ~crc;
        t = crc[31:24];
        for (int j = 0; j < 8; j++) r[j] = t[7-j];
        return r[7:2];
    endfunction

    // Leaves the bench at the negedge of the done cycle
    task automatic run_frame(input logic [47:0] a);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            byte_valid_i = 1'b1;
            byte_i = a[47-8*k -: 8];
            @(negedge clk);
        end
        byte_valid_i = 1'b0;
    endtask

    task automatic clear_ctl();
        rx_all_i = 0; acc_bcast_i = 0; acc_mcast_all_i = 0; hash_en_i = 0;
        gig_mode_i = 0; hash_lo_i = '0; hash_hi_i = '0;
    endtask

    task automatic t_reset();
        check("R1 reset done", done_o, 0);
        check("R1 reset accept", accept_o, 0);
        check("R1 reset flags", {bcast_o, mcast_o}, 0);
        check("R1 reset idx", hash_idx_o, 0);
    endtask

    task automatic t_unicast();
        clear_ctl();
        run_frame(STATION);
        check("R2 done after sixth", done_o, 1);
        check("R8 station accept", accept_o, 1);
        check("R8 flags clear", {bcast_o, mcast_o}, 0);
        @(negedge clk);
        check("R2 done one cycle", done_o, 0);
        check("R9 accept held", accept_o, 1);
        run_frame(48'h02_11_22_33_44_54);
        check("R8 last byte mismatch", accept_o, 0);
        run_frame(48'h55_44_33_22_11_02);
        check("R8 byte order", accept_o, 0);
        rx_all_i = 1;
        run_frame(48'h55_44_33_22_11_02);
        check("R10 rx_all accepts mismatch", accept_o, 1);
    endtask

    task automatic t_bcast();
        clear_ctl();
        run_frame(48'hFF_FF_FF_FF_FF_FF);
        check("R3 bcast flag", bcast_o, 1);
        check("R3 bcast rejected", accept_o, 0);
        acc_bcast_i = 1;
        run_frame(48'hFF_FF_FF_FF_FF_FF);
        check("R3 bcast accepted", accept_o, 1);
        clear_ctl(); rx_all_i = 1;
        run_frame(48'hFF_FF_FF_FF_FF_FF);
        check("R3 bcast rx_all", accept_o, 1);
    endtask

    task automatic t_mcast_detect();
        clear_ctl(); acc_mcast_all_i = 1;
        run_frame(48'h01_00_5E_80_00_01);
        check("R4 fourth byte 0x80 not mcast", mcast_o, 0);
        check("R4 0x80 rejected", accept_o, 0);
        run_frame(48'h01_00_5E_7F_00_01);
        check("R4 fourth byte 0x7F mcast", mcast_o, 1);
        check("R5 accept all multicast", accept_o, 1);
    endtask

    task automatic t_hash();
        logic [47:0] a = 48'h01_00_5E_12_34_56;
        logic [47:0] b = 48'h01_00_5E_00_00_01;
        logic [5:0]  ia = ref_idx(a, 6);
        logic [5:0]  ib = ref_idx(b, 6);
        clear_ctl(); hash_en_i = 1;
        if (ia[5]) hash_hi_i[ia[4:0]] = 1'b1; else hash_lo_i[ia[4:0]] = 1'b1;
        run_frame(a);
        check("R6 hash index a", hash_idx_o, ia);
        check("R5 hash bit accept", accept_o, 1);
        hash_en_i = 0;
        run_frame(a);
        check("R5 hash disabled reject", accept_o, 0);
        hash_en_i = 1; hash_lo_i = '0; hash_hi_i = '0;
        if (ia[5]) hash_lo_i[ia[4:0]] = 1'b1; else hash_hi_i[ia[4:0]] = 1'b1;
        run_frame(a);
        check("R5 wrong word reject", accept_o, 0);
        hash_lo_i = '0; hash_hi_i = '0;
        if (ib[5]) hash_hi_i[ib[4:0]] = 1'b1; else hash_lo_i[ib[4:0]] = 1'b1;
        run_frame(b);
        check("R6 hash index b", hash_idx_o, ib);
        check("R5 hash bit accept b", accept_o, 1);
    endtask

    task automatic t_gig();
        logic [47:0] a = 48'h01_00_5E_12_34_56;
        clear_ctl(); gig_mode_i = 1;
        run_frame(a);
        check("R7 five byte hash", hash_idx_o, ref_idx(a, 5));
        run_frame(48'h01_00_5E_12_34_A9);
        check("R7 sixth byte ignored", hash_idx_o, ref_idx(a, 5));
    endtask

    task automatic t_restart();
        clear_ctl();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        for (int k = 0; k < 3; k++) begin
            byte_valid_i = 1; byte_i = 8'hFF; @(negedge clk);
        end
        byte_valid_i = 0;
        check("R1 no done mid frame", done_o, 0);
        run_frame(STATION);
        check("R1 restart accept", accept_o, 1);
        check("R1 restart bcast clear", bcast_o, 0);
    endtask

    task automatic t_extra();
        logic [5:0] held;
        clear_ctl();
        run_frame(48'h01_00_5E_01_02_03);
        held = hash_idx_o;
        @(negedge clk);
        byte_valid_i = 1; byte_i = 8'h77;
        @(negedge clk); @(negedge clk);
        byte_valid_i = 0;
        check("R9 extra bytes idx", hash_idx_o, held);
        check("R9 extra bytes flag", mcast_o, 1);
        check("R9 no second done", done_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_bcast();
        t_mcast_detect();
        t_hash();
        t_gig();
        t_restart();
        t_extra();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule